// File: doc/BRIEF.md
# Framed Serial Result and Register Port

This block is the slave side of a four-wire serial link between a converter's digital back end and a host. It runs on the host's serial clock. Frame sync (active low) and input data are sampled on falling edges, and the output pin changes on rising edges, so each output bit is stable at the falling edge where the host samples it. In every frame the port shifts out one 32-bit word, MSB first: the 24-bit conversion result followed by 8 status bits. In the same frame it shifts in 32 bits, a 16-bit register address followed by a 16-bit data word.

The port contains three 16-bit registers: a control word, a gain word and an overrange threshold. Two bits of the control word choose a register to be read back. A host reads a register in two frames. The first frame writes the control word with the choice. A later frame, which must start at least eight serial-clock periods after the end of that write, then carries the chosen register in place of the result. After that one frame the choice is used up.

For daisy chaining, the host keeps frame sync low past the end of the port's own 32 bits. The port then sends its data input to its data output through one register stage, until frame sync is seen high again. A frame that ends with frame sync still low is treated as a chained read and writes nothing.

Top module: `conv_serial_port`

## Requirements
- R1: After reset, sdo, wr_stb and chain_o are 0, ctrl_q is 0x0000, gain_q is 0xA000 and thr_q is 0xF000.
- R2: A frame starts at a falling edge of sclk that samples fs_n low when the previous falling edge sampled it high. The output word {result_i, status_i}, taken at the start edge, is sent MSB first. Bit i (counting from the MSB, i = 0..31) is launched on a rising edge and is stable at the (i+1)-th falling edge after the start.
- R3: Input bits are captured at the 1st to 32nd falling edges after the start: bits 31..16 form the address and bits 15..0 form the data, MSB first. If fs_n is sampled high at the 32nd edge, wr_stb is high for exactly one sclk period after that edge, while wr_addr and wr_data show the received fields.
- R4: The registers decode the address: 0x0001 is the control word, 0x0002 is gain and 0x0003 is the threshold. The addressed register takes wr_data at the falling edge that ends the strobe.
- R5: A frame whose address is not one of those three still raises wr_stb, but it changes no register.
- R6: Control bits [1:0] choose a register for readback: 01 is gain, 10 is the threshold, 11 is the control word, and 00 is none. The first frame that starts at least 8 sclk periods after the 32nd edge of that control write sends {register, 8'h00, status_i} instead of the result. After this, the choice is cleared and later frames send the result again.
- R7: A frame that starts fewer than 8 sclk periods after a control write sends the normal result word. The readback choice stays pending for a later frame.
- R8: If fs_n is sampled low at the 32nd edge, no strobe is produced and the port enters pass-through. Each sdi value sampled at a falling edge is driven onto sdo at the next rising edge, and chain_o is 1. Pass-through ends at the first falling edge that samples fs_n high, and sdo then returns to 0.
- R9: Changes of fs_n during a frame, before the 32nd edge, neither restart nor shorten the frame.
- R10: When the port is neither in a frame nor in pass-through, sdo is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock from the host |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_n | input | 1 | Frame sync, active low |
| sdi | input | 1 | Serial data in (address/data, or chained data) |
| sdo | output | 1 | Serial data out |
| result_i | input | 24 | Conversion result to send |
| status_i | input | 8 | Status bits to send |
| wr_stb | output | 1 | One-period pulse after a complete write frame |
| wr_addr | output | 16 | Received register address |
| wr_data | output | 16 | Received data word |
| ctrl_q | output | 16 | Control register |
| gain_q | output | 16 | Gain register |
| thr_q | output | 16 | Overrange threshold register |
| chain_o | output | 1 | Pass-through mode active |

## Verification
The hardest cases to reach from the ports are the two sides of the readback settling window. A frame must start exactly seven or exactly eight sclk periods after the edge that finished a control write, and the choice must survive the early frame and be used by the later one. The bench places the start of each frame to a single period. It holds fs_n low at exactly the sample that makes a frame start, and inserts a counted number of idle periods after each write. Pass-through is reached by keeping fs_n low through the 32nd sample, and its one-stage delay is checked bit by bit with a known pattern.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  // readback choice held in control bits [1:0]
  typedef enum logic [1:0] {
    RB_NONE = 2'd0,
    RB_GAIN = 2'd1,
    RB_THR  = 2'd2,
    RB_CTRL = 2'd3
  } rb_sel_e;
endpackage

// File: rtl/ssp_rst_sync.sv
module ssp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  // assert asynchronously, release on the sampling (falling) edge
  always_ff @(negedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/ssp_frame_ctl.sv
module ssp_frame_ctl #(
  parameter int FRAME_LEN = 32
) (
  input  logic sclk,
  input  logic rst_n,
  input  logic fs_n,
  output logic start,
  output logic capture,
  output logic wr_ok,
  output logic active_q,
  output logic chain_q
);
  localparam int CW = $clog2(FRAME_LEN);

  logic          fs_lo;
  logic          fs_prev_q;
  logic          last;
  logic          active_d, chain_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign fs_lo = ~fs_n;

  always_comb begin
    start    = !active_q && !chain_q && fs_lo && fs_prev_q;
    capture  = active_q;
    last     = active_q && (cnt_q == CW'(FRAME_LEN - 1));
    wr_ok    = last && !fs_lo;
    active_d = active_q;
    cnt_d    = cnt_q;
    chain_d  = chain_q;
    if (start) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (capture) begin
      if (last) begin
        active_d = 1'b0;
        cnt_d    = '0;
        chain_d  = fs_lo;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (chain_q && !fs_lo) chain_d = 1'b0;
  end

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      fs_prev_q <= 1'b1;
      active_q  <= 1'b0;
      cnt_q     <= '0;
      chain_q   <= 1'b0;
    end else begin
      fs_prev_q <= fs_n;
      active_q  <= active_d;
      cnt_q     <= cnt_d;
      chain_q   <= chain_d;
    end
  end

  // R9: frame sync activity cannot end a frame before its last bit
  p_no_early_end_r9: assert property (@(negedge sclk) disable iff (!rst_n)
    (active_q && cnt_q != CW'(FRAME_LEN - 1)) |=> active_q);
endmodule

// File: rtl/ssp_shift.sv
module ssp_shift #(
  parameter int FRAME_W = 32,
  parameter int IN_W    = 32
) (
  input  logic               sclk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_word,
  input  logic               shift_en,
  input  logic               sdi,
  output logic               tx_msb,
  output logic [IN_W-1:0]    rx_word,
  output logic               pass_bit
);
  logic [FRAME_W-1:0] tx_q, tx_d;
  logic [IN_W-1:0]    rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    if (load)          tx_d = load_word;
    else if (shift_en) tx_d = {tx_q[FRAME_W-2:0], 1'b0};
    rx_d = {rx_q[IN_W-2:0], sdi};
  end

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q     <= '0;
      rx_q     <= '0;
      pass_bit <= 1'b0;
    end else begin
      if (load || shift_en) tx_q <= tx_d;
      if (shift_en)         rx_q <= rx_d;
      pass_bit <= sdi;
    end
  end

  assign tx_msb  = tx_q[FRAME_W-1];
  assign rx_word = rx_q;
endmodule

// File: rtl/ssp_regs.sv
module ssp_regs
  import ssp_pkg::*;
#(
  parameter int          RES_W     = 24,
  parameter int          STAT_W    = 8,
  parameter int          AW        = 16,
  parameter int          DW        = 16,
  parameter int          GAP       = 8,
  parameter logic [15:0] ADDR_CTRL = 16'h0001,
  parameter logic [15:0] ADDR_GAIN = 16'h0002,
  parameter logic [15:0] ADDR_THR  = 16'h0003,
  parameter logic [15:0] GAIN_RST  = 16'hA000,
  parameter logic [15:0] THR_RST   = 16'hF000,
  localparam int         FRAME_W   = RES_W + STAT_W
) (
  input  logic               sclk,
  input  logic               rst_n,
  input  logic               wr_stb,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic               start,
  input  logic [RES_W-1:0]   result_i,
  input  logic [STAT_W-1:0]  status_i,
  output logic [FRAME_W-1:0] load_word,
  output logic [DW-1:0]      ctrl_q,
  output logic [DW-1:0]      gain_q,
  output logic [DW-1:0]      thr_q
);
  localparam int GAP_MAX = GAP - 2;
  localparam int GW      = $clog2(GAP_MAX + 2);
  localparam int PAD     = RES_W - DW;

  logic             hit_ctrl, hit_gain, hit_thr;
  logic             armed;
  rb_sel_e          rb_q, rb_d;
  logic [GW-1:0]    gap_q, gap_d;
  logic [DW-1:0]    rb_val;
  logic [RES_W-1:0] rb_field;

  always_comb begin
    hit_ctrl = wr_stb && (wr_addr == AW'(ADDR_CTRL));
    hit_gain = wr_stb && (wr_addr == AW'(ADDR_GAIN));
    hit_thr  = wr_stb && (wr_addr == AW'(ADDR_THR));
    armed    = (rb_q != RB_NONE) && (gap_q == GW'(GAP_MAX)) && !hit_ctrl;
    case (rb_q)
      RB_GAIN: rb_val = gain_q;
      RB_THR:  rb_val = thr_q;
      RB_CTRL: rb_val = ctrl_q;
      default: rb_val = '0;
    endcase
  end

  generate
    if (PAD > 0) begin : g_pad
      assign rb_field = {rb_val, {PAD{1'b0}}};
    end else begin : g_nopad
      assign rb_field = rb_val[DW-1 -: RES_W];
    end
  endgenerate

  always_comb begin
    load_word = (start && armed) ? {rb_field, status_i} : {result_i, status_i};
    rb_d      = rb_q;
    if (start && armed) rb_d = RB_NONE;
    if (hit_ctrl)       rb_d = rb_sel_e'(wr_data[1:0]);
    if (hit_ctrl)                       gap_d = '0;
    else if (gap_q != GW'(GAP_MAX))     gap_d = gap_q + 1'b1;
    else                                gap_d = gap_q;
  end

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      gain_q <= DW'(GAIN_RST);
      thr_q  <= DW'(THR_RST);
      rb_q   <= RB_NONE;
      gap_q  <= GW'(GAP_MAX);
    end else begin
      if (hit_ctrl) ctrl_q <= wr_data;
      if (hit_gain) gain_q <= wr_data;
      if (hit_thr)  thr_q  <= wr_data;
      rb_q  <= rb_d;
      gap_q <= gap_d;
    end
  end

  // R5: a strobe to an undecoded address leaves every register untouched
  p_unknown_ignored_r5: assert property (@(negedge sclk) disable iff (!rst_n)
    (wr_stb && wr_addr != AW'(ADDR_CTRL) && wr_addr != AW'(ADDR_GAIN) &&
     wr_addr != AW'(ADDR_THR)) |=> ($stable(ctrl_q) && $stable(gain_q) && $stable(thr_q)));

  // R6: a readback choice is used by exactly one frame
  p_rb_consume_r6: assert property (@(negedge sclk) disable iff (!rst_n)
    (start && armed) |=> (rb_q == RB_NONE));
endmodule

// File: rtl/conv_serial_port.sv
module conv_serial_port #(
  parameter int          RES_W     = 24,
  parameter int          STAT_W    = 8,
  parameter int          AW        = 16,
  parameter int          DW        = 16,
  parameter int          GAP       = 8,
  parameter int          SYNC_STG  = 2,
  parameter logic [15:0] ADDR_CTRL = 16'h0001,
  parameter logic [15:0] ADDR_GAIN = 16'h0002,
  parameter logic [15:0] ADDR_THR  = 16'h0003,
  parameter logic [15:0] GAIN_RST  = 16'hA000,
  parameter logic [15:0] THR_RST   = 16'hF000
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              fs_n,
  input  logic              sdi,
  output logic              sdo,
  input  logic [RES_W-1:0]  result_i,
  input  logic [STAT_W-1:0] status_i,
  output logic              wr_stb,
  output logic [AW-1:0]     wr_addr,
  output logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     ctrl_q,
  output logic [DW-1:0]     gain_q,
  output logic [DW-1:0]     thr_q,
  output logic              chain_o
);
  localparam int FRAME_W   = RES_W + STAT_W;
  localparam int IN_W      = AW + DW;
  localparam int FRAME_LEN = (FRAME_W > IN_W) ? FRAME_W : IN_W;

  logic               rst_s;
  logic               start, capture, wr_ok, act_q, chain_q;
  logic               tx_msb, pass_bit;
  logic [IN_W-1:0]    rx_word;
  logic [FRAME_W-1:0] load_word;
  logic               wr_stb_q;
  logic               sdo_q, sdo_d;

  ssp_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk(sclk), .arst_n(rst_n), .srst_n(rst_s)
  );

  ssp_frame_ctl #(.FRAME_LEN(FRAME_LEN)) u_frm (
    .sclk(sclk), .rst_n(rst_s), .fs_n(fs_n), .start(start), .capture(capture),
    .wr_ok(wr_ok), .active_q(act_q), .chain_q(chain_q)
  );

  ssp_shift #(.FRAME_W(FRAME_W), .IN_W(IN_W)) u_shf (
    .sclk(sclk), .rst_n(rst_s), .load(start), .load_word(load_word),
    .shift_en(capture), .sdi(sdi), .tx_msb(tx_msb), .rx_word(rx_word),
    .pass_bit(pass_bit)
  );

  ssp_regs #(
    .RES_W(RES_W), .STAT_W(STAT_W), .AW(AW), .DW(DW), .GAP(GAP),
    .ADDR_CTRL(ADDR_CTRL), .ADDR_GAIN(ADDR_GAIN), .ADDR_THR(ADDR_THR),
    .GAIN_RST(GAIN_RST), .THR_RST(THR_RST)
  ) u_regs (
    .sclk(sclk), .rst_n(rst_s), .wr_stb(wr_stb_q), .wr_addr(wr_addr),
    .wr_data(wr_data), .start(start), .result_i(result_i), .status_i(status_i),
    .load_word(load_word), .ctrl_q(ctrl_q), .gain_q(gain_q), .thr_q(thr_q)
  );

  // strobe raised at the edge that captures the last input bit
  always_ff @(negedge sclk or negedge rst_s) begin
    if (!rst_s) wr_stb_q <= 1'b0;
    else        wr_stb_q <= wr_ok;
  end

  // output launch on the rising edge
  always_comb sdo_d = act_q ? tx_msb : (chain_q ? pass_bit : 1'b0);

  always_ff @(posedge sclk or negedge rst_s) begin
    if (!rst_s) sdo_q <= 1'b0;
    else        sdo_q <= sdo_d;
  end

  assign sdo     = sdo_q;
  assign wr_stb  = wr_stb_q;
  assign wr_addr = rx_word[IN_W-1 -: AW];
  assign wr_data = rx_word[DW-1:0];
  assign chain_o = chain_q;

  // R3: a strobe only follows a frame that was active one edge earlier
  p_stb_after_frame_r3: assert property (@(negedge sclk) disable iff (!rst_s)
    wr_stb_q |-> $past(act_q));

  // R8: chained frames never write
  p_no_stb_chain_r8: assert property (@(negedge sclk) disable iff (!rst_s)
    chain_q |-> !wr_stb_q);

  // R10: idle launches a low output
  p_sdo_idle_r10: assert property (@(negedge sclk) disable iff (!rst_s)
    (!act_q && !chain_q) |-> (sdo_q == 1'b0));
endmodule

// File: tb/sim_conv_serial_port.sv
`timescale 1ns/1ps
module sim_conv_serial_port;
  localparam real HALF = 2.0;

  logic        sclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fs_n = 1'b1;
  logic        sdi = 1'b0;
  logic [23:0] result_i = '0;
  logic [7:0]  status_i = '0;
  logic        sdo, wr_stb, chain_o;
  logic [15:0] wr_addr, wr_data, ctrl_q, gain_q, thr_q;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_ctrl = 16'h0000;
  logic [15:0] exp_gain = 16'hA000;
  logic [15:0] exp_thr  = 16'hF000;

  always #(HALF) sclk = ~sclk;

  conv_serial_port u0 (
    .sclk(sclk), .rst_n(rst_n), .fs_n(fs_n), .sdi(sdi), .sdo(sdo),
    .result_i(result_i), .status_i(status_i), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .ctrl_q(ctrl_q), .gain_q(gain_q),
    .thr_q(thr_q), .chain_o(chain_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // one step: just after a rising edge, between the two sampling edges
  task automatic tick;
    @(posedge sclk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick;
  endtask

  task automatic frame(input logic [31:0] din, input logic hold, input int glitch,
                       output logic [31:0] dout);
    tick; fs_n = 1'b0; sdi = 1'b0;
    for (int i = 0; i < 32; i++) begin
      tick;
      dout[31-i] = sdo;
      sdi  = din[31-i];
      fs_n = hold ? 1'b0 : ((i == glitch) ? 1'b0 : 1'b1);
    end
  endtask

  // full write frame plus the strobe step and the register update step
  task automatic xfer(input logic [31:0] din, input int glitch, output logic [31:0] dout,
                      output logic stb, output logic [31:0] ad);
    frame(din, 1'b0, glitch, dout);
    tick;
    stb = wr_stb;
    ad  = {wr_addr, wr_data};
    fs_n = 1'b1; sdi = 1'b0;
    tick;
  endtask

  task automatic chk_regs(input string req);
    chk(req, {16'h0, ctrl_q}, {16'h0, exp_ctrl});
    chk(req, {16'h0, gain_q}, {16'h0, exp_gain});
    chk(req, {16'h0, thr_q},  {16'h0, exp_thr});
  endtask

  task automatic t_reset;
    idle(4);
    chk("R1 sdo", {31'h0, sdo}, 32'h0);
    chk("R1 wr_stb", {31'h0, wr_stb}, 32'h0);
    chk("R1 chain_o", {31'h0, chain_o}, 32'h0);
    chk_regs("R1 regs");
  endtask

  task automatic t_write_gain;
    logic [31:0] dout, ad; logic stb;
    result_i = 24'hABCDEF; status_i = 8'h5A;
    xfer({16'h0002, 16'h1234}, -1, dout, stb, ad);
    exp_gain = 16'h1234;
    chk("R2 word", dout, 32'hABCDEF5A);
    chk("R3 strobe", {31'h0, stb}, 32'h1);
    chk("R3 addr/data", ad, 32'h00021234);
    chk("R3 strobe one period", {31'h0, wr_stb}, 32'h0);
    chk_regs("R4 gain write");
  endtask

  task automatic t_write_thr_ctrl;
    logic [31:0] dout, ad; logic stb;
    result_i = 24'h000001; status_i = 8'h80;
    xfer({16'h0003, 16'h0F0F}, -1, dout, stb, ad);
    exp_thr = 16'h0F0F;
    chk("R2 word low pattern", dout, 32'h00000180);
    chk_regs("R4 threshold write");
    idle(2);
    xfer({16'h0001, 16'h8000}, -1, dout, stb, ad);
    exp_ctrl = 16'h8000;
    chk_regs("R4 control write");
  endtask

  task automatic t_unknown;
    logic [31:0] dout, ad; logic stb;
    idle(2);
    xfer({16'h0007, 16'hFFFF}, -1, dout, stb, ad);
    chk("R5 strobe on unknown", {31'h0, stb}, 32'h1);
    chk_regs("R5 regs unchanged");
  endtask

  task automatic t_readback_gain;
    logic [31:0] dout, ad; logic stb;
    result_i = 24'h123456; status_i = 8'h3C;
    idle(2);
    xfer({16'h0001, 16'h0001}, -1, dout, stb, ad);
    exp_ctrl = 16'h0001;
    idle(5);  // start exactly 8 periods after the write's last edge
    xfer(32'h0, -1, dout, stb, ad);
    chk("R6 readback gain at 8", dout, {exp_gain, 8'h00, 8'h3C});
    idle(5);
    xfer(32'h0, -1, dout, stb, ad);
    chk("R6 choice consumed", dout, 32'h1234563C);
  endtask

  task automatic t_gap;
    logic [31:0] dout, ad; logic stb;
    result_i = 24'h0F00F0; status_i = 8'hC3;
    idle(2);
    xfer({16'h0001, 16'h0002}, -1, dout, stb, ad);
    exp_ctrl = 16'h0002;
    idle(4);  // 7 periods: too early
    xfer(32'h0, -1, dout, stb, ad);
    chk("R7 early frame normal", dout, 32'h0F00F0C3);
    idle(5);
    xfer(32'h0, -1, dout, stb, ad);
    chk("R7 pending choice used later", dout, {exp_thr, 8'h00, 8'hC3});
  endtask

  task automatic t_rb_ctrl;
    logic [31:0] dout, ad; logic stb;
    status_i = 8'h11;
    idle(2);
    xfer({16'h0001, 16'h4003}, -1, dout, stb, ad);
    exp_ctrl = 16'h4003;
    idle(10);
    xfer(32'h0, -1, dout, stb, ad);
    chk("R6 readback control", dout, {16'h4003, 8'h00, 8'h11});
  endtask

  task automatic t_glitch;
    logic [31:0] dout, ad; logic stb;
    result_i = 24'h55AA55; status_i = 8'h0F;
    idle(3);
    xfer({16'h0002, 16'hBEEF}, 10, dout, stb, ad);
    exp_gain = 16'hBEEF;
    chk("R9 word intact", dout, 32'h55AA550F);
    chk("R9 strobe", {31'h0, stb}, 32'h1);
    chk_regs("R9 write intact");
  endtask

  task automatic t_chain;
    logic [31:0] dout;
    logic [7:0]  pat = 8'b1011_0010;
    logic        seen_stb = 1'b0;
    logic        pass_ok = 1'b1;
    result_i = 24'hFEDCBA; status_i = 8'h98;
    idle(3);
    frame(32'h00010003, 1'b1, -1, dout);
    chk("R8 own word", dout, 32'hFEDCBA98);
    tick;
    chk("R8 first forwarded bit", {31'h0, sdo}, 32'h1);
    chk("R8 chain_o", {31'h0, chain_o}, 32'h1);
    seen_stb = wr_stb;
    sdi = pat[7]; fs_n = 1'b0;
    for (int j = 7; j >= 0; j--) begin
      tick;
      if (wr_stb) seen_stb = 1'b1;
      if (sdo !== pat[j]) begin
        pass_ok = 1'b0;
        $display("FAIL R8 pass bit %0d actual=%b expected=%b", j, sdo, pat[j]);
      end
      sdi  = (j > 0) ? pat[j-1] : 1'b0;
      fs_n = (j > 0) ? 1'b0 : 1'b1;
    end
    chk("R8 pass-through delay", {31'h0, pass_ok}, 32'h1);
    chk("R8 no strobe", {31'h0, seen_stb}, 32'h0);
    tick;
    chk("R8 exit sdo", {31'h0, sdo}, 32'h0);
    chk("R8 exit chain_o", {31'h0, chain_o}, 32'h0);
    chk_regs("R8 regs unchanged");
  endtask

  task automatic t_idle;
    logic any_high = 1'b0;
    sdi = 1'b1;
    for (int i = 0; i < 10; i++) begin
      tick;
      if (sdo) any_high = 1'b1;
    end
    sdi = 1'b0;
    chk("R10 idle sdo low", {31'h0, any_high}, 32'h0);
  endtask

  initial begin : watchdog
    #(4.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary;
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge sclk);
    #1 rst_n = 1'b1;
    t_reset;
    t_write_gain;
    t_write_thr_ctrl;
    t_unknown;
    t_readback_gain;
    t_gap;
    t_rb_ctrl;
    t_glitch;
    t_chain;
    t_idle;
    summary;
    $finish;
  end
endmodule